// File: doc/BRIEF.md
# Descriptor Cache Flush Sequencer

This block takes decoded flush and unblock commands aimed at a small descriptor cache and runs them one at a time. A flush command targets one 40-bit descriptor address. It can ask for the packets held in that descriptor's queue to be forwarded first. It can also ask for a second flush of the companion extended descriptor. A separate control bit selects whether the cache line stays valid after it is written out. The cache array, the packet forwarder and descriptor memory sit outside the block, and each is reached through a request/acknowledge pair.

Four indexed blocking resources each hold one blocked address. A flush command can free its indexed resource, claim it for its own address, or do both in one command: the release happens first and the claim second. Illegal uses abort the command before any request is issued. A whole-cache flush skips every per-address field, blocks the entire cache until a whole-cache unblock command arrives, and leaves the four resources as they are. A lookup port reports whether an address is refused because it matches a blocked address or because the whole cache is blocked. When the command asks for it, the block returns a status word that echoes the command number and carries a 2-bit result code.

Top module: `flush_cmd_ctrl`

## Requirements
- R1: After reset, cmd_ready_o is 1. No forward request, flush request or status is active, and no lookup is reported blocked.
- R2: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both 1. cmd_ready_o stays 0 from the next cycle until the command has finished, so only one command is in flight at a time.
- R3: A flush command with its release bit set whose indexed resource is free ends with code 1 (release error). It issues no request and changes no resource.
- R4: A flush command with its block bit set whose indexed resource is busy, and whose release bit is clear, ends with code 2 (block-busy error). It issues no request and changes no resource.
- R5: Release and block set together on a busy resource succeed with code 0. The resource then holds the new address, and the old address is no longer blocked.
- R6: A successful block makes lk_blocked_o equal 1 for a lookup of exactly that address, until an unblock frees it. Lookups of other addresses are not affected.
- R7: When the forward bit is set, fwd_req_o is raised first, and fl_req_o is raised only after fwd_ack_i is seen.
- R8: fl_inv_o is 1 on a flush unless the keep-valid bit is set. fl_addr_o carries the command address.
- R9: When the extended bit is set, a second flush with fl_ext_o equal to 1 follows the acknowledged primary flush, which has fl_ext_o equal to 0.
- R10: A whole-cache flush issues exactly one flush request with fl_all_o equal to 1, and no forward or extended request. It sets cache_blocked_o, which blocks every lookup until a whole-cache unblock. The four resources are left unchanged.
- R11: A status word is produced only when the status-required bit is set. It is a one-cycle pulse on stat_valid_o with stat_num_o equal to the command number, and stat_code_o is 0 (ok), 1 (release error) or 2 (block-busy error).
- R12: An indexed unblock command frees a busy resource with code 0. If the resource is already free, it returns code 1 and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_num_i | input | 16 | Command number echoed in status |
| cmd_stat_req_i | input | 1 | Status word wanted |
| cmd_unblk_i | input | 1 | Command is an unblock (otherwise a flush) |
| cmd_unblk_all_i | input | 1 | Unblock targets the whole cache |
| cmd_addr_i | input | 40 | Descriptor address |
| cmd_fwd_i | input | 1 | Forward queued packets before flushing |
| cmd_rel_i | input | 1 | Release indexed resource first |
| cmd_idx_i | input | 2 | Blocking resource index |
| cmd_keep_i | input | 1 | Keep line valid after write-out |
| cmd_blk_i | input | 1 | Claim indexed resource for this address |
| cmd_all_i | input | 1 | Flush the whole cache |
| cmd_ext_i | input | 1 | Also flush the extended descriptor |
| fwd_req_o | output | 1 | Forward request |
| fwd_ack_i | input | 1 | Forward done |
| fl_req_o | output | 1 | Flush request |
| fl_addr_o | output | 40 | Flush address |
| fl_inv_o | output | 1 | Invalidate after write-out |
| fl_ext_o | output | 1 | Flush targets the extended descriptor |
| fl_all_o | output | 1 | Flush targets every line |
| fl_ack_i | input | 1 | Flush done |
| stat_valid_o | output | 1 | Status pulse |
| stat_num_o | output | 16 | Echoed command number |
| stat_code_o | output | 2 | 0 ok, 1 release error, 2 block-busy error |
| lk_addr_i | input | 40 | Lookup address |
| lk_blocked_o | output | 1 | Lookup refused |
| cache_blocked_o | output | 1 | Whole cache blocked |

## Verification
The hardest case to reach from the ports is the atomic release-then-claim on a resource that is already busy. The stimulus first claims a resource with one address, then tries a plain second claim, which must fail. Only after that does it send the combined release-and-claim with a new address, and probes of both addresses show that the switch happened. A second hard case is a whole-cache flush issued while one resource is held. It carries every per-address bit set, and it must neither forward nor touch that resource. The checks on this rely on lookups made after the whole-cache unblock.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_REL_ERR  = 2'd1,
    ST_BUSY_ERR = 2'd2
  } stat_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FWD, S_FLUSH, S_EXT, S_DONE
  } seq_state_e;
endpackage

// File: rtl/flush_block_regs.sv
module flush_block_regs #(
  parameter int AW      = 40,
  parameter int NUM_RES = 4,
  parameter int IW      = $clog2(NUM_RES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_en_i,
  input  logic               set_en_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               all_set_i,
  input  logic               all_clr_i,
  input  logic [AW-1:0]      lk_addr_i,
  output logic [NUM_RES-1:0] busy_o,
  output logic               lk_blocked_o,
  output logic               all_blocked_o
);
  logic [NUM_RES-1:0] hit;

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    logic          vld_q;
    logic [AW-1:0] adr_q;
    logic          sel;
    assign sel = (idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        adr_q <= '0;
      end else if (sel && set_en_i) begin
        // set wins over a same-command release
        vld_q <= 1'b1;
        adr_q <= addr_i;
      end else if (sel && clr_en_i) begin
        vld_q <= 1'b0;
      end
    end
    assign busy_o[g] = vld_q;
    assign hit[g]    = vld_q && (adr_q == lk_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        all_blocked_o <= 1'b0;
    else if (all_set_i) all_blocked_o <= 1'b1;
    else if (all_clr_i) all_blocked_o <= 1'b0;
  end

  assign lk_blocked_o = all_blocked_o || (|hit);
endmodule

// File: rtl/flush_seq_fsm.sv
module flush_seq_fsm
  import flush_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       go_i,
  input  logic       fwd_i,
  input  logic       ext_q_i,
  input  logic       fwd_ack_i,
  input  logic       fl_ack_i,
  output seq_state_e state_o
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      S_IDLE:  if (accept_i) state_d = !go_i ? S_DONE : (fwd_i ? S_FWD : S_FLUSH);
      S_FWD:   if (fwd_ack_i) state_d = S_FLUSH;
      S_FLUSH: if (fl_ack_i) state_d = ext_q_i ? S_EXT : S_DONE;
      S_EXT:   if (fl_ack_i) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/flush_cmd_ctrl.sv
module flush_cmd_ctrl
  import flush_pkg::*;
#(
  parameter int AW      = 40,
  parameter int NW      = 16,
  parameter int NUM_RES = 4,
  localparam int IW     = $clog2(NUM_RES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [NW-1:0] cmd_num_i,
  input  logic          cmd_stat_req_i,
  input  logic          cmd_unblk_i,
  input  logic          cmd_unblk_all_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic          cmd_fwd_i,
  input  logic          cmd_rel_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic          cmd_keep_i,
  input  logic          cmd_blk_i,
  input  logic          cmd_all_i,
  input  logic          cmd_ext_i,
  output logic          fwd_req_o,
  input  logic          fwd_ack_i,
  output logic          fl_req_o,
  output logic [AW-1:0] fl_addr_o,
  output logic          fl_inv_o,
  output logic          fl_ext_o,
  output logic          fl_all_o,
  input  logic          fl_ack_i,
  output logic          stat_valid_o,
  output logic [NW-1:0] stat_num_o,
  output logic [1:0]    stat_code_o,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_blocked_o,
  output logic          cache_blocked_o
);
  seq_state_e         state;
  logic               accept, res_busy, go;
  logic               clr_en, set_en, all_set, all_clr;
  stat_code_e         code_d, code_q;
  logic [NUM_RES-1:0] busy_vec;
  logic [NW-1:0]      num_q;
  logic [AW-1:0]      addr_q;
  logic               sreq_q, keep_q, ext_q, all_q;

  assign accept   = cmd_valid_i && cmd_ready_o;
  assign res_busy = busy_vec[cmd_idx_i];

  // command legality check against the resource state at accept time
  always_comb begin
    code_d  = ST_OK;
    go      = 1'b0;
    clr_en  = 1'b0;
    set_en  = 1'b0;
    all_set = 1'b0;
    all_clr = 1'b0;
    if (cmd_unblk_i) begin
      if (cmd_unblk_all_i)  all_clr = 1'b1;
      else if (!res_busy)   code_d  = ST_REL_ERR;
      else                  clr_en  = 1'b1;
    end else if (cmd_all_i) begin
      all_set = 1'b1;
      go      = 1'b1;
    end else if (cmd_rel_i && !res_busy) begin
      code_d = ST_REL_ERR;
    end else if (cmd_blk_i && res_busy && !cmd_rel_i) begin
      code_d = ST_BUSY_ERR;
    end else begin
      go     = 1'b1;
      clr_en = cmd_rel_i;
      set_en = cmd_blk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      addr_q <= '0;
      sreq_q <= 1'b0;
      keep_q <= 1'b0;
      ext_q  <= 1'b0;
      all_q  <= 1'b0;
      code_q <= ST_OK;
    end else if (accept) begin
      num_q  <= cmd_num_i;
      addr_q <= cmd_addr_i;
      sreq_q <= cmd_stat_req_i;
      keep_q <= cmd_keep_i;
      ext_q  <= cmd_ext_i && !cmd_all_i && !cmd_unblk_i;
      all_q  <= cmd_all_i && !cmd_unblk_i;
      code_q <= code_d;
    end
  end

  flush_block_regs #(.AW(AW), .NUM_RES(NUM_RES), .IW(IW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_en_i      (accept && clr_en),
    .set_en_i      (accept && set_en),
    .idx_i         (cmd_idx_i),
    .addr_i        (cmd_addr_i),
    .all_set_i     (accept && all_set),
    .all_clr_i     (accept && all_clr),
    .lk_addr_i     (lk_addr_i),
    .busy_o        (busy_vec),
    .lk_blocked_o  (lk_blocked_o),
    .all_blocked_o (cache_blocked_o)
  );

  flush_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .go_i      (go),
    .fwd_i     (cmd_fwd_i && !cmd_all_i),
    .ext_q_i   (ext_q),
    .fwd_ack_i (fwd_ack_i),
    .fl_ack_i  (fl_ack_i),
    .state_o   (state)
  );

  assign cmd_ready_o  = (state == S_IDLE);
  assign fwd_req_o    = (state == S_FWD);
  assign fl_req_o     = (state == S_FLUSH) || (state == S_EXT);
  assign fl_ext_o     = (state == S_EXT);
  assign fl_all_o     = fl_req_o && all_q;
  assign fl_inv_o     = fl_req_o && (all_q || !keep_q);
  assign fl_addr_o    = addr_q;
  assign stat_valid_o = (state == S_DONE) && sreq_q;
  assign stat_num_o   = num_q;
  assign stat_code_o  = code_q;
endmodule

module flush_cmd_ctrl_chk #(
  parameter int AW = 40
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic          fwd_req_o,
  input logic          fwd_ack_i,
  input logic          fl_req_o,
  input logic [AW-1:0] fl_addr_o,
  input logic          fl_ext_o,
  input logic          fl_all_o,
  input logic          fl_ack_i,
  input logic          stat_valid_o,
  input logic [1:0]    stat_code_o,
  input logic          lk_blocked_o,
  input logic          cache_blocked_o
);
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);
  assert_fwd_fl_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_req_o && fl_req_o));
  assert_fwd_then_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_req_o && fwd_ack_i |=> fl_req_o && !fl_ext_o);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o && !fl_ack_i |=> fl_req_o && $stable(fl_addr_o) && $stable(fl_ext_o));
  assert_all_no_ext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_all_o |-> !fl_ext_o);
  assert_whole_blocks_lookup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_blocked_o |-> lk_blocked_o);
  assert_stat_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);
  assert_code_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> stat_code_o != 2'd3);
endmodule

bind flush_cmd_ctrl flush_cmd_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/flush_cmd_ctrl_tb.sv
module flush_cmd_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_ready_o;
  logic [15:0] cmd_num_i = '0;
  logic        cmd_stat_req_i = 1'b0, cmd_unblk_i = 1'b0, cmd_unblk_all_i = 1'b0;
  logic [39:0] cmd_addr_i = '0;
  logic        cmd_fwd_i = 1'b0, cmd_rel_i = 1'b0, cmd_keep_i = 1'b0;
  logic [1:0]  cmd_idx_i = '0;
  logic        cmd_blk_i = 1'b0, cmd_all_i = 1'b0, cmd_ext_i = 1'b0;
  logic        fwd_req_o, fwd_ack_i = 1'b0;
  logic        fl_req_o, fl_inv_o, fl_ext_o, fl_all_o, fl_ack_i = 1'b0;
  logic [39:0] fl_addr_o;
  logic        stat_valid_o;
  logic [15:0] stat_num_o;
  logic [1:0]  stat_code_o;
  logic [39:0] lk_addr_i = '0;
  logic        lk_blocked_o, cache_blocked_o;

  int n_vec = 0, n_err = 0;

  // reference state
  bit          m_vld [4];
  logic [39:0] m_adr [4];
  bit          m_all = 0;

  always #5 clk_i = ~clk_i;

  flush_cmd_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_blocked(input logic [39:0] a);
    bit r = m_all;
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_adr[i] == a) r = 1;
    return r;
  endfunction

  // compared on every clock
  always @(negedge clk_i) if (rst_ni) begin
    chk(lk_blocked_o == exp_blocked(lk_addr_i), "R6 lookup", lk_blocked_o, exp_blocked(lk_addr_i));
    chk(cache_blocked_o == m_all, "R10 whole-cache", cache_blocked_o, m_all);
  end

  task automatic do_cmd(input bit unb, input bit unb_all, input bit all, input bit rel,
                        input bit blk, input bit fwd, input bit keep, input bit ext,
                        input bit sreq, input logic [1:0] idx, input logic [39:0] addr,
                        input logic [15:0] num, input string tag);
    int  code = 0, n_fwd = 0, n_fl = 0, n_st = 0;
    bit  go = 0, order_ok = 1, f_inv = 0, f_all = 0, f_ext0 = 0, f_ext1 = 0;
    logic [39:0] f_adr = '0;
    logic [1:0]  s_code = '0;
    logic [15:0] s_num = '0;
    @(negedge clk_i);
    {cmd_unblk_i, cmd_unblk_all_i, cmd_all_i, cmd_rel_i, cmd_blk_i} = {unb, unb_all, all, rel, blk};
    {cmd_fwd_i, cmd_keep_i, cmd_ext_i, cmd_stat_req_i} = {fwd, keep, ext, sreq};
    cmd_idx_i = idx; cmd_addr_i = addr; cmd_num_i = num; cmd_valid_i = 1'b1;
    chk(cmd_ready_o == 1'b1, "R2 ready idle", cmd_ready_o, 1);
    @(posedge clk_i);
    // reference update from the requirements
    if (unb) begin
      if (unb_all) m_all = 0;
      else if (!m_vld[idx]) code = 1;
      else m_vld[idx] = 0;
    end else if (all) begin
      m_all = 1; go = 1;
    end else if (rel && !m_vld[idx]) code = 1;
    else if (blk && m_vld[idx] && !rel) code = 2;
    else begin
      go = 1;
      if (rel) m_vld[idx] = 0;
      if (blk) begin m_vld[idx] = 1; m_adr[idx] = addr; end
    end
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(cmd_ready_o == 1'b0, {"R2 busy ", tag}, cmd_ready_o, 0);
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk_i);
      if (fwd_ack_i || fl_ack_i) begin
        fwd_ack_i = 1'b0; fl_ack_i = 1'b0;
      end else begin
        if (fwd_req_o) begin
          n_fwd++; if (n_fl != 0) order_ok = 0; fwd_ack_i = 1'b1;
        end
        if (fl_req_o) begin
          if (n_fl == 0) begin f_inv = fl_inv_o; f_all = fl_all_o; f_adr = fl_addr_o; f_ext0 = fl_ext_o; end
          else f_ext1 = fl_ext_o;
          n_fl++; fl_ack_i = 1'b1;
        end
      end
      if (stat_valid_o) begin n_st++; s_code = stat_code_o; s_num = stat_num_o; end
      if (cmd_ready_o) break;
    end
    chk(n_fwd == ((go && fwd && !all) ? 1 : 0), {"R7 fwd count ", tag}, n_fwd, (go && fwd && !all));
    chk(order_ok, {"R7 fwd before flush ", tag}, order_ok, 1);
    chk(n_fl == (!go ? 0 : (all ? 1 : (ext ? 2 : 1))), {"R9 R10 flush count ", tag}, n_fl,
        !go ? 0 : (all ? 1 : (ext ? 2 : 1)));
    if (go) begin
      chk(f_all == all, {"R10 all flag ", tag}, f_all, all);
      chk(f_ext0 == 0, {"R9 primary ext ", tag}, f_ext0, 0);
      if (!all) begin
        chk(f_inv == !keep, {"R8 invalidate ", tag}, f_inv, !keep);
        chk(f_adr == addr, {"R8 address ", tag}, f_adr, addr);
        if (ext) chk(f_ext1 == 1, {"R9 second ext ", tag}, f_ext1, 1);
      end
    end
    chk(n_st == (sreq ? 1 : 0), {"R11 status count ", tag}, n_st, sreq);
    if (sreq) begin
      chk(s_code == 2'(code), {"R3 R4 R12 code ", tag}, s_code, code);
      chk(s_num == num, {"R11 number ", tag}, s_num, num);
    end
  endtask

  task automatic probe(input logic [39:0] a, input bit exp, input string tag);
    @(negedge clk_i);
    lk_addr_i = a;
    @(negedge clk_i);
    chk(lk_blocked_o == exp, {"R6 probe ", tag}, lk_blocked_o, exp);
  endtask

  localparam logic [39:0] A = 40'h12_3456_7890;
  localparam logic [39:0] B = 40'hAB_CDEF_0120;
  localparam logic [39:0] C = 40'h00_0000_0FF0;

  initial begin
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_adr[i] = '0; end
    repeat (3) @(posedge clk_i);
    #1;
    chk(cmd_ready_o == 1 && !fwd_req_o && !fl_req_o && !stat_valid_o && !lk_blocked_o,
        "R1 reset state", {cmd_ready_o, fwd_req_o, fl_req_o, stat_valid_o, lk_blocked_o}, 5'b10000);
    rst_ni = 1'b1;
    // plain flush, invalidate
    do_cmd(0,0,0,0,0,0,0,0,1, 2'd1, C, 16'h0001, "plain");
    // forward + keep + extended + block idx0 with A
    do_cmd(0,0,0,0,1,1,1,1,1, 2'd0, A, 16'h0002, "R5 setup");
    probe(A, 1, "A blocked");
    probe(B, 0, "B free");
    // R4: claim busy index without release
    do_cmd(0,0,0,0,1,0,0,0,1, 2'd0, B, 16'h0003, "R4 busy");
    probe(B, 0, "B still free after R4");
    // R5: release-then-claim
    do_cmd(0,0,0,1,1,0,0,0,1, 2'd0, B, 16'h0004, "R5 swap");
    probe(A, 0, "A released");
    probe(B, 1, "B blocked");
    // R3: release of free index
    do_cmd(0,0,0,1,0,0,0,0,1, 2'd2, C, 16'h0005, "R3 rel free");
    // R11: error without status
    do_cmd(0,0,0,1,0,0,0,0,0, 2'd2, C, 16'h0006, "R11 silent");
    // R12: unblock free index, then busy index
    do_cmd(1,0,0,0,0,0,0,0,1, 2'd1, '0, 16'h0007, "R12 free");
    do_cmd(1,0,0,0,0,0,0,0,1, 2'd0, '0, 16'h0008, "R12 busy");
    probe(B, 0, "B unblocked");
    // R10: hold idx3 with C, then whole-cache flush with every field set
    do_cmd(0,0,0,0,1,0,0,0,1, 2'd3, C, 16'h0009, "R10 setup");
    do_cmd(0,0,1,1,1,1,1,1,1, 2'd3, A, 16'h000A, "R10 all");
    probe(A, 1, "A under whole-cache");
    do_cmd(1,1,0,0,0,0,0,0,1, 2'd0, '0, 16'h000B, "R10 unblock all");
    probe(A, 0, "A after unblock all");
    probe(C, 1, "C kept R10");
    do_cmd(0,0,0,0,1,0,0,0,1, 2'd3, B, 16'h000C, "R10 idx3 still busy");
    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #2_000_000;
    n_vec++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule